// File: doc/BRIEF.md
# Flash buffer DMA engine

This block copies one chunk of 32-bit words between system memory and the internal data buffer of a flash controller. Software sets it up through a small register bank. It writes a memory byte address, a flash-buffer byte address and a byte length, and then it writes a command word. Command value 0 copies memory into the buffer. Command value 1 copies the buffer out to memory. When the chunk ends, the engine sets a sticky done field and holds an interrupt high until software writes zero to that field. A memory-side bus error ends the transfer at once and is latched in a separate error register, which software also clears by writing zero. Any write to the stop register aborts a running transfer. A configuration bit reverses the byte order inside each word in both directions. Chaining several chunks is done by software outside the block.

The engine is a six-state machine:
- **IDLE** waits for a command.
- **MEM_RD** holds a memory read request until it is acknowledged or fails.
- **FB_WR** writes the captured word into the buffer.
- **FB_RD** issues a buffer read.
- **FB_WAIT** captures the buffer word one cycle later.
- **MEM_WR** holds a memory write request until it is acknowledged or fails.

The transitions are as follows:
- An accepted command leaves IDLE for MEM_RD (command 0) or for FB_RD (command 1). With a length of zero it stays in IDLE and completes on the spot.
- An acknowledge moves MEM_RD to FB_WR and MEM_WR to FB_RD.
- FB_RD always moves to FB_WAIT, and FB_WAIT always moves to MEM_WR.
- After the last word, FB_WR (command 0) or the acknowledged MEM_WR (command 1) returns to IDLE with completion. Otherwise FB_WR loops back to MEM_RD, and MEM_WR continues to FB_RD.
- A bus error in MEM_RD or MEM_WR returns to IDLE with completion and error.
- A stop write returns any state to IDLE without completion.

The default length after reset is one 512-byte chunk.

Top module: `fbuf_dma`

## Requirements
- R1: After reset, reads give status 0, done 0, error 0, config 0 and length 512 (0x200), and irq is low.
- R2: Software reads back what it wrote, at these byte offsets. Config bits [1:0] are at 0x00. The memory address at 0x04 keeps bits [31:2]. The buffer address at 0x08 keeps bits [FB_AW+1:2]. The length at 0x0C keeps bits [15:2]. The last accepted command is at 0x10, bit 0. Bits not kept read 0. The stop register (0x14) and unmapped offsets read 0.
- R3: A write of bit0=0 to offset 0x10 while idle starts a memory-to-buffer transfer, and status bit 0 (offset 0x18) reads 1 from the next cycle. For word i the engine reads memory at address+4i, then writes the returned word into the buffer at word index (buffer address/4)+i.
- R4: A write of bit0=1 to offset 0x10 while idle starts a buffer-to-memory transfer. For word i the engine reads buffer word (buffer address/4)+i and writes it to memory at address+4i.
- R5: After the last word, status reads 0, done (offset 0x1C, bits [1:0]) reads 01 and irq is high. Writing 0 to done clears it and drops irq. Writing a nonzero value leaves it unchanged.
- R6: A memory error response ends the transfer in that cycle with no further words moved. Done then reads 11, error (offset 0x20, bit 0) reads 1 and status reads 0. Writing 0 clears the error bit, and a nonzero write leaves it set.
- R7: Any write to offset 0x14 during a transfer returns the engine to idle in the next cycle. After that no memory request is issued and done stays 00.
- R8: With config bit 1 set, every word is byte-reversed on its way through, in both directions.
- R9: Command writes during a transfer are ignored, and the command register keeps its old value. Address and length writes during a transfer do not alter the running transfer.
- R10: A command with length 0 completes at once: done reads 01 and no memory request is made.
- R11: A memory request keeps the same address, direction and write data until it is acknowledged or answered with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request, held until ack or error |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request completed |
| mem_err | input | 1 | Memory request failed |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| fb_en | output | 1 | Buffer access enable |
| fb_we | output | 1 | Buffer write enable |
| fb_addr | output | FB_AW | Buffer word index |
| fb_wdata | output | 32 | Buffer write data |
| fb_rdata | input | 32 | Buffer read data, one cycle after a read |
| irq | output | 1 | High while the done field is nonzero |

## Verification
A wrong address or length counter shows up at the first bus beat that goes to the wrong place. A wrong swap latch shows up as wrong data at the first buffer or memory write. A stuck or early state exit shows up as a word count that differs from the programmed length once status drops. The bench checks the address and data of every memory response and every buffer write against its own list of expected beats. A stall or lost request is therefore caught within one word. A lost done or error flag is caught at the register read that follows the status change.

// File: rtl/fbuf_dma_pkg.sv
package fbuf_dma_pkg;

    localparam logic [5:0] OFS_CFG  = 6'h00;
    localparam logic [5:0] OFS_MADR = 6'h04;
    localparam logic [5:0] OFS_XADR = 6'h08;
    localparam logic [5:0] OFS_LEN  = 6'h0C;
    localparam logic [5:0] OFS_CMD  = 6'h10;
    localparam logic [5:0] OFS_STOP = 6'h14;
    localparam logic [5:0] OFS_STAT = 6'h18;
    localparam logic [5:0] OFS_DONE = 6'h1C;
    localparam logic [5:0] OFS_ERR  = 6'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_RD,
        ST_FB_WR,
        ST_FB_RD,
        ST_FB_WAIT,
        ST_MEM_WR
    } eng_state_t;

    function automatic logic [31:0] bswap32(input logic [31:0] d, input logic en);
        return en ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endfunction

endpackage

// File: rtl/fbuf_dma_regs.sv
module fbuf_dma_regs
    import fbuf_dma_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int FB_AW       = 9,
    parameter int CHUNK_BYTES = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [5:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 busy,
    input  logic                 fin,
    input  logic                 fin_err,
    output logic                 start,
    output logic                 start_rd,
    output logic                 stop,
    output logic                 cfg_swap,
    output logic [31:0]          prog_madr,
    output logic [FB_AW-1:0]     prog_xidx,
    output logic [LEN_W-3:0]     prog_lenw,
    output logic                 irq
);
    localparam int LW_W = LEN_W - 2;
    localparam logic [LW_W-1:0] CHUNK_WORDS = LW_W'(CHUNK_BYTES / 4);

    logic [1:0]       cfg_q;
    logic [29:0]      madr_q;
    logic [FB_AW-1:0] xidx_q;
    logic [LW_W-1:0]  lenw_q;
    logic             cmd_q;
    logic [1:0]       done_q;
    logic             err_q;

    assign start    = reg_wr && (reg_addr == OFS_CMD) && !busy;
    assign start_rd = reg_wdata[0];
    assign stop     = reg_wr && (reg_addr == OFS_STOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            madr_q <= '0;
            xidx_q <= '0;
            lenw_q <= CHUNK_WORDS;
            cmd_q  <= 1'b0;
            done_q <= 2'b00;
            err_q  <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    OFS_CFG:  cfg_q  <= reg_wdata[1:0];
                    OFS_MADR: madr_q <= reg_wdata[31:2];
                    OFS_XADR: xidx_q <= reg_wdata[FB_AW+1:2];
                    OFS_LEN:  lenw_q <= reg_wdata[LEN_W-1:2];
                    default: ;
                endcase
            end
            if (start) cmd_q <= reg_wdata[0];
            if (fin)
                done_q <= fin_err ? 2'b11 : 2'b01;
            else if (reg_wr && reg_addr == OFS_DONE && reg_wdata == 32'd0)
                done_q <= 2'b00;
            if (fin_err)
                err_q <= 1'b1;
            else if (reg_wr && reg_addr == OFS_ERR && reg_wdata == 32'd0)
                err_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG:  reg_rdata[1:0] = cfg_q;
            OFS_MADR: reg_rdata = {madr_q, 2'b00};
            OFS_XADR: reg_rdata[FB_AW+1:0] = {xidx_q, 2'b00};
            OFS_LEN:  reg_rdata[LEN_W-1:0] = {lenw_q, 2'b00};
            OFS_CMD:  reg_rdata[0] = cmd_q;
            OFS_STAT: reg_rdata[0] = busy;
            OFS_DONE: reg_rdata[1:0] = done_q;
            OFS_ERR:  reg_rdata[0] = err_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign cfg_swap  = cfg_q[1];
    assign prog_madr = {madr_q, 2'b00};
    assign prog_xidx = xidx_q;
    assign prog_lenw = lenw_q;
    assign irq       = (done_q != 2'b00);

    // R5: completion raises the interrupt on the following cycle
    p_done_sets_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> irq);

    // R6: an error completion latches the error flag and both done bits
    p_err_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_err |=> (err_q && done_q == 2'b11));

endmodule

// File: rtl/fbuf_dma_engine.sv
module fbuf_dma_engine
    import fbuf_dma_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int FB_AW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic             stop,
    input  logic             swap,
    input  logic [31:0]      prog_madr,
    input  logic [FB_AW-1:0] prog_xidx,
    input  logic [LEN_W-3:0] prog_lenw,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [31:0]      mem_rdata,
    output logic             fb_en,
    output logic             fb_we,
    output logic [FB_AW-1:0] fb_addr,
    output logic [31:0]      fb_wdata,
    input  logic [31:0]      fb_rdata,
    output logic             busy,
    output logic             fin,
    output logic             fin_err
);
    localparam int LW_W = LEN_W - 2;

    eng_state_t       state, nxt;
    logic [31:0]      cur_m;
    logic [FB_AW-1:0] cur_x;
    logic [LW_W-1:0]  left_q;
    logic [31:0]      data_q;
    logic             swap_q;
    logic             last;
    logic             step;

    assign last = (left_q == LW_W'(1));
    assign step = (state == ST_FB_WR) || (state == ST_MEM_WR && mem_ack && !mem_err);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_m  <= '0;
            cur_x  <= '0;
            left_q <= '0;
            data_q <= '0;
            swap_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                cur_m  <= prog_madr;
                cur_x  <= prog_xidx;
                left_q <= prog_lenw;
                swap_q <= swap;
            end
            if (state == ST_MEM_RD && mem_ack) data_q <= bswap32(mem_rdata, swap_q);
            if (state == ST_FB_WAIT)           data_q <= bswap32(fb_rdata, swap_q);
            if (step) begin
                cur_m  <= cur_m + 32'd4;
                cur_x  <= cur_x + FB_AW'(1);
                left_q <= left_q - LW_W'(1);
            end
        end
    end

    always_comb begin
        nxt     = state;
        fin     = 1'b0;
        fin_err = 1'b0;
        if (stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (prog_lenw == '0) fin = 1'b1;
                        else nxt = start_rd ? ST_FB_RD : ST_MEM_RD;
                    end
                end
                ST_MEM_RD: begin
                    if (mem_err) begin
                        nxt = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
                    end else if (mem_ack) begin
                        nxt = ST_FB_WR;
                    end
                end
                ST_FB_WR: begin
                    if (last) begin nxt = ST_IDLE; fin = 1'b1; end
                    else nxt = ST_MEM_RD;
                end
                ST_FB_RD:   nxt = ST_FB_WAIT;
                ST_FB_WAIT: nxt = ST_MEM_WR;
                ST_MEM_WR: begin
                    if (mem_err) begin
                        nxt = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
                    end else if (mem_ack) begin
                        if (last) begin nxt = ST_IDLE; fin = 1'b1; end
                        else nxt = ST_FB_RD;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state == ST_MEM_RD) || (state == ST_MEM_WR);
        mem_we    = (state == ST_MEM_WR);
        mem_addr  = cur_m;
        mem_wdata = data_q;
        fb_en     = (state == ST_FB_WR) || (state == ST_FB_RD);
        fb_we     = (state == ST_FB_WR);
        fb_addr   = cur_x;
        fb_wdata  = data_q;
        busy      = (state != ST_IDLE);
    end

    // R11: an unanswered request stays unchanged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !stop) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: a stop write idles the engine on the next cycle
    p_stop_idles_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy);

    // R6: an error response ends the transfer and drops the request
    p_err_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (!busy && !mem_req));

endmodule

// File: rtl/fbuf_dma.sv
module fbuf_dma
    import fbuf_dma_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int FB_AW       = 9,
    parameter int CHUNK_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [5:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [31:0]      mem_rdata,
    output logic             fb_en,
    output logic             fb_we,
    output logic [FB_AW-1:0] fb_addr,
    output logic [31:0]      fb_wdata,
    input  logic [31:0]      fb_rdata,
    output logic             irq
);
    logic             busy, fin, fin_err, start, start_rd, stop, cfg_swap;
    logic [31:0]      prog_madr;
    logic [FB_AW-1:0] prog_xidx;
    logic [LEN_W-3:0] prog_lenw;

    fbuf_dma_regs #(.LEN_W(LEN_W), .FB_AW(FB_AW), .CHUNK_BYTES(CHUNK_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .fin(fin),
        .fin_err(fin_err), .start(start), .start_rd(start_rd), .stop(stop),
        .cfg_swap(cfg_swap), .prog_madr(prog_madr), .prog_xidx(prog_xidx),
        .prog_lenw(prog_lenw), .irq(irq)
    );

    fbuf_dma_engine #(.LEN_W(LEN_W), .FB_AW(FB_AW)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd), .stop(stop),
        .swap(cfg_swap), .prog_madr(prog_madr), .prog_xidx(prog_xidx),
        .prog_lenw(prog_lenw), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .fb_en(fb_en), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
        .busy(busy), .fin(fin), .fin_err(fin_err)
    );

endmodule

// File: tb/fbuf_dma_bench.sv
`timescale 1ns/1ps
module fbuf_dma_bench;
    localparam int FB_AW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [5:0] reg_addr = 6'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we, fb_en, fb_we, irq;
    logic [31:0] mem_addr, mem_wdata, fb_wdata;
    logic [FB_AW-1:0] fb_addr;
    logic mem_ack = 1'b0;
    logic mem_err = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic [31:0] fb_rdata = 32'h0;

    always #5 clk = ~clk;

    fbuf_dma #(.FB_AW(FB_AW)) u_fbuf_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .fb_en(fb_en), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
        .fb_rdata(fb_rdata), .irq(irq)
    );

    function automatic logic [31:0] mval(input logic [31:0] a);
        return {~a[15:0], a[15:0] ^ 16'h3C5A};
    endfunction
    function automatic logic [31:0] rev(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // expectation lists, written only by the main process
    logic [31:0] exp_ma [0:127];
    logic [31:0] exp_md [0:127];
    logic        exp_mchk [0:127];
    int          m_wr = 0, m_base = 0;
    logic [FB_AW-1:0] exp_fi [0:127];
    logic [31:0] exp_fd [0:127];
    int          f_wr = 0, f_base = 0;
    int          lat = 1;
    int          err_at = -1;

    // memory model (negedge): owns its pointer and counters
    bit [31:0] mem_model [0:255];
    bit        mem_valid [0:255];
    int m_rd = 0, wcnt = 0, req_cnt = 0, resp_cnt = 0, m_chk = 0, m_err = 0;
    logic [31:0] hold_a = 0, hold_d = 0;

    always @(negedge clk) begin
        if (mem_req) req_cnt++;
        if (mem_ack || mem_err) begin
            mem_ack = 1'b0; mem_err = 1'b0; wcnt = 0;
        end else if (mem_req) begin
            if (wcnt > 0) begin
                m_chk++;
                if (mem_addr !== hold_a || mem_wdata !== hold_d) begin
                    m_err++;
                    $display("FAIL R11 request changed while waiting: addr %h exp %h", mem_addr, hold_a);
                end
            end
            hold_a = mem_addr; hold_d = mem_wdata;
            if (wcnt >= lat) begin
                if (m_rd < m_base) m_rd = m_base;
                m_chk++;
                if (m_rd >= m_wr) begin
                    m_err++;
                    $display("FAIL R3 unexpected memory request addr %h exp none", mem_addr);
                end else begin
                    if (mem_addr !== exp_ma[m_rd]) begin
                        m_err++;
                        $display("FAIL R3 memory address %h exp %h", mem_addr, exp_ma[m_rd]);
                    end
                    if (mem_we && exp_mchk[m_rd] && mem_wdata !== exp_md[m_rd]) begin
                        m_err++;
                        $display("FAIL R4 memory write data %h exp %h", mem_wdata, exp_md[m_rd]);
                    end
                    m_rd++;
                end
                if (resp_cnt == err_at) begin
                    mem_err = 1'b1;
                end else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem_model[mem_addr[9:2]] = mem_wdata;
                        mem_valid[mem_addr[9:2]] = 1'b1;
                    end else begin
                        mem_rdata = mem_valid[mem_addr[9:2]] ? mem_model[mem_addr[9:2]] : mval(mem_addr);
                    end
                end
                resp_cnt++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    // flash buffer model (posedge, one-cycle read latency)
    bit [31:0] fb_model [0:(1<<FB_AW)-1];
    int f_rd = 0, f_chk = 0, f_err = 0;

    always @(posedge clk) begin
        if (fb_en && fb_we) begin
            if (f_rd < f_base) f_rd = f_base;
            f_chk++;
            if (f_rd >= f_wr) begin
                f_err++;
                $display("FAIL R3 unexpected buffer write idx %0d exp none", fb_addr);
            end else begin
                if (fb_addr !== exp_fi[f_rd] || fb_wdata !== exp_fd[f_rd]) begin
                    f_err++;
                    $display("FAIL R3 buffer write idx %0d data %h exp idx %0d data %h",
                             fb_addr, fb_wdata, exp_fi[f_rd], exp_fd[f_rd]);
                end
                f_rd++;
            end
            fb_model[fb_addr] = fb_wdata;
        end else if (fb_en) begin
            fb_rdata <= fb_model[fb_addr];
        end
    end

    int checks = 0, errors = 0, cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            $display("FAIL watchdog expired, act %0d cycles exp fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors",
                     checks + m_chk + f_chk + 1, errors + m_err + f_err + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rchk(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        chk(d === exp, req, d, exp);
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 3000; k++) begin
            rd(6'h18, d);
            if (!d[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic push_m(input logic [31:0] a, input logic [31:0] d, input bit c);
        exp_ma[m_wr] = a; exp_md[m_wr] = d; exp_mchk[m_wr] = c; m_wr++;
    endtask
    task automatic push_f(input int i, input logic [31:0] d);
        exp_fi[f_wr] = FB_AW'(i); exp_fd[f_wr] = d; f_wr++;
    endtask
    task automatic flush();
        m_base = m_wr; f_base = f_wr;
    endtask

    task automatic end_counts(input string req);
        chk(m_rd == m_wr, req, m_rd, m_wr);
        chk(f_rd == f_wr || f_base == f_wr, req, f_rd, f_wr);
    endtask

    initial begin
        logic [31:0] d;
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rchk(6'h18, 32'h0, "R1 status");
        rchk(6'h1C, 32'h0, "R1 done");
        rchk(6'h20, 32'h0, "R1 error");
        rchk(6'h00, 32'h0, "R1 config");
        rchk(6'h0C, 32'h200, "R1 length");
        chk(irq === 1'b0, "R1 irq", {31'h0, irq}, 32'h0);

        // R2 readback
        wr(6'h00, 32'h1);        rchk(6'h00, 32'h1, "R2 config");
        wr(6'h04, 32'h43);       rchk(6'h04, 32'h40, "R2 memory address");
        wr(6'h08, 32'h23);       rchk(6'h08, 32'h20, "R2 buffer address");
        wr(6'h0C, 32'h13);       rchk(6'h0C, 32'h10, "R2 length");
        rchk(6'h14, 32'h0, "R2 stop reads zero");
        rchk(6'h24, 32'h0, "R2 unmapped reads zero");

        // R3 memory to buffer, 4 words
        flush(); lat = 1;
        for (int i = 0; i < 4; i++) begin
            push_m(32'h40 + 4*i, 0, 1'b0);
            push_f(8 + i, mval(32'h40 + 4*i));
        end
        wr(6'h10, 32'h0);
        rchk(6'h18, 32'h1, "R3 status active after command");
        wait_idle();
        end_counts("R3 beat count");
        rchk(6'h1C, 32'h1, "R5 done after transfer");
        chk(irq === 1'b1, "R5 irq high", {31'h0, irq}, 32'h1);
        wr(6'h1C, 32'h5);        rchk(6'h1C, 32'h1, "R5 nonzero write keeps done");
        wr(6'h1C, 32'h0);        rchk(6'h1C, 32'h0, "R5 zero write clears done");
        chk(irq === 1'b0, "R5 irq low", {31'h0, irq}, 32'h0);

        // R4 buffer to memory, 3 words from idx 8
        flush(); lat = 0;
        wr(6'h04, 32'h80); wr(6'h08, 32'h20); wr(6'h0C, 32'hC);
        for (int i = 0; i < 3; i++) push_m(32'h80 + 4*i, mval(32'h40 + 4*i), 1'b1);
        wr(6'h10, 32'h1);
        wait_idle();
        end_counts("R4 beat count");
        rchk(6'h10, 32'h1, "R4 command readback");
        chk(mem_model[(32'h88)>>2] === mval(32'h48), "R4 memory content",
            mem_model[(32'h88)>>2], mval(32'h48));
        rchk(6'h1C, 32'h1, "R4 done");
        wr(6'h1C, 32'h0);

        // R8 byte swap, both directions
        flush(); lat = 1;
        wr(6'h00, 32'h3); wr(6'h04, 32'h180); wr(6'h08, 32'h100); wr(6'h0C, 32'h8);
        for (int i = 0; i < 2; i++) begin
            push_m(32'h180 + 4*i, 0, 1'b0);
            push_f(32'h40 + i, rev(mval(32'h180 + 4*i)));
        end
        wr(6'h10, 32'h0);
        wait_idle();
        end_counts("R8 swapped write count");
        wr(6'h1C, 32'h0);
        flush();
        wr(6'h04, 32'h1C0);
        for (int i = 0; i < 2; i++) push_m(32'h1C0 + 4*i, mval(32'h180 + 4*i), 1'b1);
        wr(6'h10, 32'h1);
        wait_idle();
        end_counts("R8 swapped read count");
        chk(mem_model[(32'h1C4)>>2] === mval(32'h184), "R8 swapped read content",
            mem_model[(32'h1C4)>>2], mval(32'h184));
        wr(6'h1C, 32'h0); wr(6'h00, 32'h1);

        // R6 bus error on third word
        flush(); lat = 1;
        wr(6'h04, 32'h240); wr(6'h08, 32'h0); wr(6'h0C, 32'h10);
        for (int i = 0; i < 3; i++) push_m(32'h240 + 4*i, 0, 1'b0);
        for (int i = 0; i < 2; i++) push_f(i, mval(32'h240 + 4*i));
        err_at = resp_cnt + 2;
        wr(6'h10, 32'h0);
        wait_idle();
        end_counts("R6 words before error");
        rchk(6'h1C, 32'h3, "R6 done after error");
        rchk(6'h20, 32'h1, "R6 error flag");
        rchk(6'h18, 32'h0, "R6 status idle");
        wr(6'h20, 32'h1);        rchk(6'h20, 32'h1, "R6 nonzero write keeps error");
        wr(6'h20, 32'h0);        rchk(6'h20, 32'h0, "R6 zero write clears error");
        err_at = -1;
        wr(6'h1C, 32'h0);

        // R7 stop mid-transfer
        flush(); lat = 4;
        wr(6'h04, 32'h300); wr(6'h08, 32'h180); wr(6'h0C, 32'h40);
        for (int i = 0; i < 16; i++) begin
            push_m(32'h300 + 4*i, 0, 1'b0);
            push_f(32'h60 + i, mval(32'h300 + 4*i));
        end
        wr(6'h10, 32'h0);
        repeat (8) @(negedge clk);
        wr(6'h14, 32'h0);
        rchk(6'h18, 32'h0, "R7 idle after stop");
        snap = req_cnt;
        repeat (10) @(negedge clk);
        chk(req_cnt == snap, "R7 no requests after stop", req_cnt, snap);
        rchk(6'h1C, 32'h0, "R7 done stays clear");
        chk(irq === 1'b0, "R7 irq low", {31'h0, irq}, 32'h0);
        flush(); lat = 2;

        // R9 writes during a running transfer
        wr(6'h04, 32'h280); wr(6'h08, 32'h400); wr(6'h0C, 32'h20);
        for (int i = 0; i < 8; i++) begin
            push_m(32'h280 + 4*i, 0, 1'b0);
            push_f(32'h100 + i, mval(32'h280 + 4*i));
        end
        wr(6'h10, 32'h0);
        wr(6'h04, 32'h3F0); wr(6'h0C, 32'h4); wr(6'h10, 32'h1);
        wait_idle();
        end_counts("R9 original transfer kept");
        rchk(6'h10, 32'h0, "R9 command during transfer ignored");
        rchk(6'h0C, 32'h4, "R9 length register takes new value");
        rchk(6'h1C, 32'h1, "R9 done");
        wr(6'h1C, 32'h0);

        // R10 zero length
        flush(); lat = 1;
        wr(6'h0C, 32'h0);
        snap = req_cnt;
        wr(6'h10, 32'h0);
        rchk(6'h1C, 32'h1, "R10 done at once");
        rchk(6'h18, 32'h0, "R10 status idle");
        repeat (3) @(negedge clk);
        chk(req_cnt == snap, "R10 no memory request", req_cnt, snap);
        chk(irq === 1'b1, "R10 irq", {31'h0, irq}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors",
                 checks + m_chk + f_chk, errors + m_err + f_err);
        $finish;
    end
endmodule